// File: doc/BRIEF.md
# Configuration Image Byte Streamer

This controller takes a configuration image held in a byte-addressable memory and pushes it, one byte per transfer, into the byte-wide load port of a programmable device. A start pulse hands it the total image size. The first sixteen bytes of the image are a header. The first four header bytes give the payload size as a big-endian 32-bit number. The other twelve header bytes (version, date, reserved) are never fetched. The controller rejects an image that cannot hold a header, or whose declared payload runs past the stated image size. It does this before it touches the device.

For an accepted image the controller pulses the device reset and waits a settle interval. It then sends one zero byte and waits again. Next it streams the payload in address order, followed by five zero bytes. Finally it looks at the error bit of the device's interrupt status word. If the bit is set the load fails. Otherwise a last settle interval passes and the controller reports done. Done and error stay asserted until the next accepted start pulse.

The memory read port is a request channel with valid/ready and a response strobe. A request holds its address until ready is seen. Only one read is ever outstanding, and a response strobe that arrives while no read is pending is ignored. The device load port is a valid/ready stream. Each valid-and-ready cycle is one write strobe. Data holds while ready is low, so the device may stall the stream for any number of cycles.

Top module: `cfg_image_loader`

## Requirements
- R1: While reset is held, done_o, error_o, cfg_valid_o, mem_req_valid_o and dev_reset_o are all low.
- R2: An image size below 16 ends the run with error_o high. There is no memory request, no device reset pulse and no load-port transfer.
- R3: The payload length is assembled big-endian from image bytes 0 (most significant) to 3. Image addresses 4 to 15 are never requested.
- R4: If 16 plus the payload length exceeds the image size, the run ends with error_o high, with no device reset pulse and no load-port transfer. The sum is computed without wrap-around.
- R5: dev_reset_o is a single-cycle pulse. At least SETTLE_CYCLES cycles pass between it and the first load-port transfer, which is a zero byte. Another settle interval separates that byte from the first payload read.
- R6: Payload byte k is read from address 16+k and transferred as the k-th payload byte. Exactly the header length of bytes is sent, in address order, and a length of zero sends none.
- R7: After the payload, exactly five zero bytes are transferred.
- R8: While cfg_valid_o is high and cfg_ready_i is low, cfg_valid_o stays high and cfg_data_o stays unchanged on the next cycle.
- R9: A memory request holds valid and address until accepted. At most one read is outstanding.
- R10: After the padding, bit ERR_BIT (default 5) of irq_status_i set ends the run with error_o. If the bit is clear, the run ends with done_o after a final settle interval.
- R11: done_o and error_o are never high together. Each stays high until the next start. A start pulse during a run is ignored, and neither port is requested during done or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when no run is in progress |
| img_len_i | input | ADDR_W | Total image size in bytes, captured at start |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory read request accepted |
| mem_req_addr_o | output | ADDR_W | Memory byte address |
| mem_rsp_valid_i | input | 1 | Read data strobe |
| mem_rsp_data_i | input | 8 | Read data byte |
| cfg_valid_o | output | 1 | Load-port byte valid |
| cfg_ready_i | input | 1 | Load port accepts the byte (write strobe when both high) |
| cfg_data_o | output | 8 | Load-port byte |
| dev_reset_o | output | 1 | Single-cycle device reset strobe |
| irq_status_i | input | STAT_W | Device interrupt status; bit ERR_BIT flags a failed load |
| done_o | output | 1 | Sticky success flag |
| error_o | output | 1 | Sticky failure flag |

## Verification
Directed images probe the acceptance edges. Sizes 10 and 15 must be refused while 16 with a zero-length header must succeed. A payload one byte larger than the image must fail, and a header length near 2^32 tells a wrapping sum apart from a correct one. Random payloads of random length, with random stalls on both the memory and load-port ready signals, check that the transferred byte list (zero, payload, five zeros) does not depend on back-pressure. Runs with the device error bit set tell a failure detected after the stream apart from the early rejections, because the full stream must still appear. A start pulse injected mid-run and a long idle stretch after done check that the outcome cannot be disturbed and that both flags stay sticky.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int HDR_BYTES = 16;
  localparam int LEN_BYTES = 4;
  localparam int BYTE_W    = 8;
  localparam int LEN_W     = LEN_BYTES * BYTE_W;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_CHECK,
    ST_HDR_ISSUE,
    ST_HDR_WAIT,
    ST_FIT,
    ST_RESET,
    ST_SETTLE_A,
    ST_DUMMY,
    ST_SETTLE_B,
    ST_PL_ISSUE,
    ST_PL_WAIT,
    ST_PL_SEND,
    ST_PAD,
    ST_SAMPLE,
    ST_SETTLE_C,
    ST_DONE,
    ST_FAIL
  } ld_state_e;
endpackage

// File: rtl/cfgld_mem_rd.sv
module cfgld_mem_rd #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  output logic              got_o
);
  logic              req_q;
  logic              wait_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      wait_q <= 1'b0;
      addr_q <= '0;
    end else begin
      if (go_i && !req_q && !wait_q) begin
        req_q  <= 1'b1;
        addr_q <= addr_i;
      end else if (req_q && req_ready_i) begin
        req_q  <= 1'b0;
        wait_q <= 1'b1;
      end else if (wait_q && rsp_valid_i) begin
        wait_q <= 1'b0;
      end
    end
  end

  assign req_valid_o = req_q;
  assign req_addr_o  = addr_q;
  assign got_o       = wait_q && rsp_valid_i;
endmodule

// File: rtl/cfgld_settle.sv
module cfgld_settle #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cfgld_len_acc.sv
module cfgld_len_acc
  import cfgld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [LEN_W-1:0]  len_o
);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       len_q <= '0;
    else if (clear_i) len_q <= '0;
    else if (shift_i) len_q <= {len_q[LEN_W-BYTE_W-1:0], byte_i};
  end

  assign len_o = len_q;
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
  import cfgld_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int SETTLE_CYCLES = 16,
  parameter int PAD_BYTES     = 5,
  parameter int STAT_W        = 8,
  parameter int ERR_BIT       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] img_len_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [BYTE_W-1:0] mem_rsp_data_i,
  output logic              cfg_valid_o,
  input  logic              cfg_ready_i,
  output logic [BYTE_W-1:0] cfg_data_o,
  output logic              dev_reset_o,
  input  logic [STAT_W-1:0] irq_status_i,
  output logic              done_o,
  output logic              error_o
);
  localparam int CMP_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

  ld_state_e         st_q, st_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] img_len_q;
  logic [BYTE_W-1:0] byte_q;
  logic [LEN_W-1:0]  pl_len;
  logic              rd_go, rd_got;
  logic [ADDR_W-1:0] rd_addr;
  logic              tmr_load, tmr_expired;
  logic              len_clear, len_shift;
  logic              idle_like, start_acc, cfg_hs;
  logic              unused_stat;

  assign unused_stat = ^irq_status_i;
  assign idle_like   = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_FAIL);
  assign start_acc   = idle_like && start_i;
  assign cfg_hs      = cfg_valid_o && cfg_ready_i;

  cfgld_mem_rd #(.ADDR_W(ADDR_W)) rd_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (rd_go),
    .addr_i      (rd_addr),
    .req_valid_o (mem_req_valid_o),
    .req_ready_i (mem_req_ready_i),
    .req_addr_o  (mem_req_addr_o),
    .rsp_valid_i (mem_rsp_valid_i),
    .got_o       (rd_got)
  );

  cfgld_settle #(.CYCLES(SETTLE_CYCLES)) settle_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .expired_o (tmr_expired)
  );

  cfgld_len_acc len_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (len_clear),
    .shift_i (len_shift),
    .byte_i  (mem_rsp_data_i),
    .len_o   (pl_len)
  );

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    rd_go     = 1'b0;
    rd_addr   = '0;
    tmr_load  = 1'b0;
    len_clear = 1'b0;
    len_shift = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start_i) begin
          st_d      = ST_CHECK;
          len_clear = 1'b1;
        end
      end
      ST_CHECK: begin
        cnt_d = '0;
        st_d  = (img_len_q < ADDR_W'(HDR_BYTES)) ? ST_FAIL : ST_HDR_ISSUE;
      end
      ST_HDR_ISSUE: begin
        rd_go   = 1'b1;
        rd_addr = ADDR_W'(cnt_q);
        st_d    = ST_HDR_WAIT;
      end
      ST_HDR_WAIT: begin
        if (rd_got) begin
          len_shift = 1'b1;
          if (cnt_q == LEN_W'(LEN_BYTES - 1)) st_d = ST_FIT;
          else begin
            cnt_d = cnt_q + LEN_W'(1);
            st_d  = ST_HDR_ISSUE;
          end
        end
      end
      ST_FIT: begin
        if (CMP_W'(HDR_BYTES) + CMP_W'(pl_len) > CMP_W'(img_len_q)) st_d = ST_FAIL;
        else st_d = ST_RESET;
      end
      ST_RESET: begin
        tmr_load = 1'b1;
        st_d     = ST_SETTLE_A;
      end
      ST_SETTLE_A: begin
        if (tmr_expired) st_d = ST_DUMMY;
      end
      ST_DUMMY: begin
        if (cfg_hs) begin
          tmr_load = 1'b1;
          st_d     = ST_SETTLE_B;
        end
      end
      ST_SETTLE_B: begin
        if (tmr_expired) begin
          cnt_d = '0;
          st_d  = (pl_len == '0) ? ST_PAD : ST_PL_ISSUE;
        end
      end
      ST_PL_ISSUE: begin
        rd_go   = 1'b1;
        rd_addr = ADDR_W'(CMP_W'(HDR_BYTES) + CMP_W'(cnt_q));
        st_d    = ST_PL_WAIT;
      end
      ST_PL_WAIT: begin
        if (rd_got) st_d = ST_PL_SEND;
      end
      ST_PL_SEND: begin
        if (cfg_hs) begin
          if (cnt_q + LEN_W'(1) == pl_len) begin
            cnt_d = '0;
            st_d  = ST_PAD;
          end else begin
            cnt_d = cnt_q + LEN_W'(1);
            st_d  = ST_PL_ISSUE;
          end
        end
      end
      ST_PAD: begin
        if (cfg_hs) begin
          if (cnt_q == LEN_W'(PAD_BYTES - 1)) st_d = ST_SAMPLE;
          else cnt_d = cnt_q + LEN_W'(1);
        end
      end
      ST_SAMPLE: begin
        if (irq_status_i[ERR_BIT]) st_d = ST_FAIL;
        else begin
          tmr_load = 1'b1;
          st_d     = ST_SETTLE_C;
        end
      end
      ST_SETTLE_C: begin
        if (tmr_expired) st_d = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      img_len_q <= '0;
      byte_q    <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (start_acc) img_len_q <= img_len_i;
      if ((st_q == ST_PL_WAIT) && rd_got) byte_q <= mem_rsp_data_i;
    end
  end

  assign cfg_valid_o = (st_q == ST_DUMMY) || (st_q == ST_PL_SEND) || (st_q == ST_PAD);
  assign cfg_data_o  = (st_q == ST_PL_SEND) ? byte_q : '0;
  assign dev_reset_o = (st_q == ST_RESET);
  assign done_o      = (st_q == ST_DONE);
  assign error_o     = (st_q == ST_FAIL);
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
  parameter int ADDR_W        = 32,
  parameter int SETTLE_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic              cfg_valid_o,
  input logic              cfg_ready_i,
  input logic [7:0]        cfg_data_o,
  input logic              dev_reset_o,
  input logic              done_o,
  input logic              error_o
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1) + 1;
  logic [SW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           since_q <= '0;
    else if (dev_reset_o)                 since_q <= '0;
    else if (since_q < SW'(SETTLE_CYCLES)) since_q <= since_q + SW'(1);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_rst_state_R1: assert (!done_o && !error_o && !cfg_valid_o && !mem_req_valid_o && !dev_reset_o)
        else $error("outputs active during reset");
    end
  end

  assert_hdr_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> !((mem_req_addr_o >= ADDR_W'(4)) && (mem_req_addr_o < ADDR_W'(16))));

  assert_rst_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_o |=> !dev_reset_o);

  assert_settle_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid_o |-> (since_q >= SW'(SETTLE_CYCLES)));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid_o && !cfg_ready_i) |=> (cfg_valid_o && $stable(cfg_data_o)));

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && error_o));

  assert_quiet_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || error_o) |-> (!cfg_valid_o && !mem_req_valid_o && !dev_reset_o));
endmodule

bind cfg_image_loader cfgld_chk #(.ADDR_W(ADDR_W), .SETTLE_CYCLES(SETTLE_CYCLES)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .cfg_valid_o     (cfg_valid_o),
  .cfg_ready_i     (cfg_ready_i),
  .cfg_data_o      (cfg_data_o),
  .dev_reset_o     (dev_reset_o),
  .done_o          (done_o),
  .error_o         (error_o)
);

// File: tb/cfg_image_loader_tb_top.sv
module cfg_image_loader_tb_top;
  localparam int SETTLE = 12;
  localparam int MEMSZ  = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] img_len_i = '0;
  logic        mem_req_valid_o, mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [7:0]  mem_rsp_data_i = '0;
  logic        cfg_valid_o, cfg_ready_i = 1'b0;
  logic [7:0]  cfg_data_o;
  logic        dev_reset_o;
  logic [7:0]  irq_status_i = '0;
  logic        done_o, error_o;

  always #5 clk = ~clk;

  cfg_image_loader #(.SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .img_len_i(img_len_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .cfg_valid_o(cfg_valid_o),
    .cfg_ready_i(cfg_ready_i), .cfg_data_o(cfg_data_o), .dev_reset_o(dev_reset_o),
    .irq_status_i(irq_status_i), .done_o(done_o), .error_o(error_o)
  );

  logic [7:0] mem_b [MEMSZ];
  logic [7:0] log_q [$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  int rst_pulses, rst_cyc, first_cfg_cyc, hdr_peek, req_cnt, bad_addr;
  int pct_mem = 100, pct_cfg = 100;
  bit pend = 0;
  int pend_addr, pend_lat;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // port models: observe at negedge, drive just after posedge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
      end
      if (rst_n && mem_req_valid_o && mem_req_ready_i) begin
        req_cnt++;
        if (mem_req_addr_o >= 4 && mem_req_addr_o < 16) hdr_peek++;
        if (mem_req_addr_o >= MEMSZ) bad_addr++;
        pend = 1; pend_addr = int'(mem_req_addr_o % MEMSZ); pend_lat = $urandom % 3;
      end
      if (rst_n && cfg_valid_o && cfg_ready_i) begin
        if (log_q.size() == 0) first_cfg_cyc = cyc;
        log_q.push_back(cfg_data_o);
      end
      if (rst_n && dev_reset_o) begin rst_pulses++; rst_cyc = cyc; end
      @(posedge clk); #1;
      mem_req_ready_i = (($urandom % 100) < pct_mem);
      cfg_ready_i     = (($urandom % 100) < pct_cfg);
      mem_rsp_valid_i = 1'b0;
      if (pend && pend_lat == 0) begin
        mem_rsp_valid_i = 1'b1; mem_rsp_data_i = mem_b[pend_addr]; pend = 0;
      end else if (pend) begin
        pend_lat--;
        mem_rsp_data_i = 8'($urandom);
      end
    end
  end

  task automatic run_img(input logic [31:0] plen, input int ilen, input bit irq,
                         input int pm, input int pc, input bit mid_start);
    longint need;
    bit pre_fail, exp_ok;
    int nbytes, mism, padbad;
    need = 64'd16 + longint'(plen);
    pre_fail = (ilen < 16) || (need > longint'(ilen));
    exp_ok = !pre_fail && !irq;
    mem_b[0] = plen[31:24]; mem_b[1] = plen[23:16];
    mem_b[2] = plen[15:8];  mem_b[3] = plen[7:0];
    for (int i = 4; i < MEMSZ; i++) mem_b[i] = 8'($urandom);
    log_q.delete();
    rst_pulses = 0; hdr_peek = 0; req_cnt = 0; bad_addr = 0; first_cfg_cyc = 0; rst_cyc = 0;
    pct_mem = pm; pct_cfg = pc;
    irq_status_i = irq ? 8'h20 : 8'h00;
    @(posedge clk); #1;
    img_len_i = 32'(ilen); start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    for (int w = 0; w < 20000; w++) begin
      @(negedge clk);
      if (done_o || error_o) break;
      if (mid_start && w == 40) begin
        @(posedge clk); #1; img_len_i = 32'd5; start_i = 1'b1;
        @(posedge clk); #1; start_i = 1'b0;
      end
    end
    chk(error_o == !exp_ok, exp_ok ? "R10" : (ilen < 16 ? "R2" : "R4"), "error flag", error_o, !exp_ok);
    chk(done_o == exp_ok, "R10", "done flag", done_o, exp_ok);
    if (pre_fail) begin
      chk(log_q.size() == 0, ilen < 16 ? "R2" : "R4", "transfers", log_q.size(), 0);
      chk(rst_pulses == 0, ilen < 16 ? "R2" : "R4", "reset pulses", rst_pulses, 0);
      if (ilen < 16) chk(req_cnt == 0, "R2", "memory requests", req_cnt, 0);
    end else begin
      nbytes = int'(plen);
      chk(log_q.size() == nbytes + 6, "R6", "transfer count", log_q.size(), nbytes + 6);
      chk(rst_pulses == 1, "R5", "reset pulses", rst_pulses, 1);
      chk(first_cfg_cyc - rst_cyc >= SETTLE + 1, "R5", "reset to first byte gap",
          first_cfg_cyc - rst_cyc, SETTLE + 1);
      chk(hdr_peek == 0, "R3", "reads of bytes 4..15", hdr_peek, 0);
      chk(bad_addr == 0, "R6", "out-of-image reads", bad_addr, 0);
      if (log_q.size() == nbytes + 6) begin
        mism = 0; padbad = 0;
        chk(log_q[0] == 8'h00, "R5", "dummy byte", log_q[0], 0);
        for (int k = 0; k < nbytes; k++) if (log_q[1 + k] != mem_b[16 + k]) mism++;
        for (int k = 0; k < 5; k++) if (log_q[1 + nbytes + k] != 8'h00) padbad++;
        chk(mism == 0, "R6", "payload byte mismatches", mism, 0);
        chk(padbad == 0, "R7", "nonzero pad bytes", padbad, 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd7741));
    #2 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!done_o && !error_o && !cfg_valid_o && !mem_req_valid_o && !dev_reset_o,
        "R1", "outputs during reset", {done_o, error_o, cfg_valid_o, mem_req_valid_o, dev_reset_o}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!done_o && !error_o, "R1", "flags after reset", {done_o, error_o}, 0);

    run_img(32'd3, 10, 0, 100, 100, 0);          // R2 short
    run_img(32'd0, 15, 0, 100, 100, 0);          // R2 boundary
    run_img(32'd0, 16, 0, 100, 100, 0);          // R6/R7 zero payload, fits exactly
    run_img(32'd32, 47, 0, 70, 70, 0);           // R4 one byte short
    run_img(32'd32, 48, 0, 70, 70, 0);           // R4 exact fit
    run_img(32'hFFFF_FFF0, 256, 0, 100, 100, 0); // R4 no wrap, R3 big-endian
    run_img(32'h0000_0102, 300, 0, 100, 100, 0); // R3 multi-byte length
    run_img(32'd20, 64, 1, 60, 40, 0);           // R10 device error after full stream
    for (int t = 0; t < 6; t++) begin            // R6/R8/R9 random patterns
      int l;
      l = 1 + int'($urandom % 40);
      run_img(32'(l), l + 16 + int'($urandom % 8), 0, 30 + int'($urandom % 70),
              20 + int'($urandom % 80), 0);
    end
    run_img(32'd30, 100, 0, 50, 30, 1);          // R11 start during run ignored
    repeat (25) @(negedge clk);
    chk(done_o && !error_o, "R11", "done sticky", {done_o, error_o}, 2);
    run_img(32'd2, 8, 0, 100, 100, 0);           // R11 start from done clears done
    repeat (25) @(negedge clk);
    chk(error_o && !done_o, "R11", "error sticky", {done_o, error_o}, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule